// File: doc/BRIEF.md
# Bayer Sensor Readout Timing Emulator

This block stands in for a windowed image sensor. It scans a programmable window placed anywhere on a physical pixel array. The array has a ring of dark pixels on the outside, a thin boundary ring inside that, and the active image in the middle. For the window it drives frame-valid, line-valid and a pixel data bus, with programmable horizontal and vertical blanking. Each pixel value is a deterministic test word. The word holds the region class of the pixel's physical location, its Bayer channel and the low bits of its physical column. A checker downstream can therefore tell from the data alone where every sample came from.

The window origin, size and both blanking counts are register inputs. They are sampled only when a frame begins. The block runs in one of two modes. In free-running mode it produces frames back to back. In single-shot mode it waits for a trigger pulse, produces exactly one frame, and returns to idle. The array geometry and every region edge are parameters. The defaults describe a 2752 x 2004 array whose 2592 x 1944 active image starts at column 16, row 54.

Top module: `sensor_readout_emu`

## Requirements
- R1: While reset is asserted, frame-valid, line-valid and the data bus are all low.
- R2: A frame has H lines. Each line has W consecutive cycles with line-valid high, one per window pixel. Two lines are separated by HB cycles with line-valid low. Frame-valid stays high from the first pixel through every inter-line gap to the last pixel.
- R3: After the last pixel of a frame, frame-valid is low for VB cycles. In free-running mode the next frame's first pixel follows immediately after those cycles.
- R4: Line-valid is high only for window pixels, and the data bus is zero whenever line-valid is low.
- R5: During a pixel, bits 7:0 of the 12-bit word hold the low 8 bits of the physical column, which is the window start column plus the offset within the line. The column is zero-extended if the column address is narrower than 8 bits.
- R6: Bits 11:10 hold the region code: 0 dark, 1 boundary, 2 active. A pixel is dark if its row or its column lies in a dark band, active if both lie in the active band, and boundary otherwise. By default, columns below 10 and from 2618 are dark, columns 10–15 and 2608–2617 are boundary, rows below 50 and from 2002 are dark, and rows 50–53 and 1998–2001 are boundary.
- R7: Bits 9:8 hold the Bayer channel as {window row parity, window column parity}: 0 = Gr, 1 = R, 2 = B, 3 = Gb. The first window pixel is therefore always Gr.
- R8: The window and blanking inputs are captured only when a frame starts. Changing them during a frame leaves that frame unchanged and affects the next one.
- R9: With single-shot mode set, the block stays idle until trigger is high. A frame's first pixel appears one cycle after trigger is sampled. Exactly one frame is produced and the block then returns to idle. A trigger during a frame is ignored.
- R10: A width, height or blanking count of zero behaves as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_shot | input | 1 | 1: one frame per trigger; 0: free-running frames |
| trigger | input | 1 | Starts a frame in single-shot mode |
| win_col | input | CW | Window start column |
| win_row | input | RW | Window start row |
| win_width | input | CW | Window width in pixels |
| win_height | input | RW | Window height in lines |
| hblank | input | BLANK_W | Cycles between lines |
| vblank | input | BLANK_W | Cycles of vertical blanking after a frame |
| fv | output | 1 | Frame valid |
| lv | output | 1 | Line valid |
| dout | output | DATA_W | Test-pattern pixel word |

CW is clog2(COLS+1) and RW is clog2(ROWS+1).

## Verification
The bench places windows across the leading corner and the trailing edges of a reduced array, so that all three region codes and both parities appear in every combination. A wrong edge comparison would show up as a misclassified column or row at the exact band crossing. It also rewrites the configuration and pulses trigger in the middle of a frame. A design that sampled its registers continuously would show a shifted column in the running frame, and one that accepted late triggers would show a second frame. Zero counts are exercised as well, where an off-by-one or a wrapped counter would stretch a line or a gap to hundreds of cycles. Free-running back-to-back frames, with a switch to single-shot mode during the second frame, check the seam between vertical blanking and the next first pixel.

// File: rtl/sensor_emu_pkg.sv
`timescale 1ns/1ps
package sensor_emu_pkg;

   typedef enum logic [1:0] {
      RG_DARK = 2'd0,
      RG_EDGE = 2'd1,
      RG_LIVE = 2'd2
   } region_t;

   typedef enum logic [1:0] {
      SC_IDLE = 2'd0,
      SC_LINE = 2'd1,
      SC_HBLK = 2'd2,
      SC_VBLK = 2'd3
   } scan_t;

   // Dark wins over everything, live needs both axes live.
   function automatic region_t merge_region(region_t a, region_t b);
      if (a == RG_DARK || b == RG_DARK) return RG_DARK;
      if (a == RG_LIVE && b == RG_LIVE) return RG_LIVE;
      return RG_EDGE;
   endfunction

endpackage

// File: rtl/region_decode.sv
`timescale 1ns/1ps
module region_decode
   import sensor_emu_pkg::*;
#(
   parameter int N  = 2752,
   parameter int E0 = 10,
   parameter int E1 = 16,
   parameter int E2 = 2608,
   parameter int E3 = 2618,
   parameter int W  = 12
) (
   input  logic [W-1:0] coord,
   output region_t      kind
);
   localparam logic [W-1:0] B0 = W'(E0);
   localparam logic [W-1:0] B1 = W'(E1);
   localparam logic [W-1:0] B2 = W'(E2);
   localparam logic [W-1:0] B3 = W'(E3);

   initial begin
      edge_order_chk: assert (E0 >= 0 && E0 <= E1 && E1 <= E2 && E2 <= E3 && E3 <= N)
         else $error("region edges out of order");
      edge_width_chk: assert (N < (1 << W))
         else $error("coordinate width too small");
   end

   always_comb begin
      if (coord < B0)      kind = RG_DARK;
      else if (coord < B1) kind = RG_EDGE;
      else if (coord < B2) kind = RG_LIVE;
      else if (coord < B3) kind = RG_EDGE;
      else                 kind = RG_DARK;
   end
endmodule

// File: rtl/scan_ctrl.sv
`timescale 1ns/1ps
module scan_ctrl
   import sensor_emu_pkg::*;
#(
   parameter int CW = 12,
   parameter int RW = 11,
   parameter int BW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          single_shot,
   input  logic          trigger,
   input  logic [CW-1:0] col_i,
   input  logic [RW-1:0] row_i,
   input  logic [CW-1:0] w_i,
   input  logic [RW-1:0] h_i,
   input  logic [BW-1:0] hb_i,
   input  logic [BW-1:0] vb_i,
   output logic          fv,
   output logic          lv,
   output logic [CW-1:0] px,
   output logic [RW-1:0] ln,
   output logic [CW-1:0] col0,
   output logic [RW-1:0] row0
);
   scan_t         state;
   logic [BW-1:0] bcnt;
   logic [CW-1:0] w_q;
   logic [RW-1:0] h_q;
   logic [BW-1:0] hb_q, vb_q;

   logic [CW:0] px_nxt;
   logic [RW:0] ln_nxt;
   logic [BW:0] b_nxt;
   logic        px_last, ln_last, hb_last, vb_last, start;

   initial begin
      scan_width_chk: assert (CW > 0 && RW > 0 && BW > 0)
         else $error("scan widths must be positive");
   end

   assign px_nxt  = {1'b0, px} + (CW+1)'(1);
   assign ln_nxt  = {1'b0, ln} + (RW+1)'(1);
   assign b_nxt   = {1'b0, bcnt} + (BW+1)'(1);
   // a zero count ends on its first cycle, so it acts as one
   assign px_last = px_nxt >= {1'b0, w_q};
   assign ln_last = ln_nxt >= {1'b0, h_q};
   assign hb_last = b_nxt  >= {1'b0, hb_q};
   assign vb_last = b_nxt  >= {1'b0, vb_q};

   assign start = (state == SC_IDLE && (!single_shot || trigger)) ||
                  (state == SC_VBLK && vb_last && !single_shot);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SC_IDLE;
         px    <= '0;
         ln    <= '0;
         bcnt  <= '0;
         col0  <= '0;
         row0  <= '0;
         w_q   <= '0;
         h_q   <= '0;
         hb_q  <= '0;
         vb_q  <= '0;
      end else if (start) begin
         state <= SC_LINE;
         px    <= '0;
         ln    <= '0;
         bcnt  <= '0;
         col0  <= col_i;
         row0  <= row_i;
         w_q   <= w_i;
         h_q   <= h_i;
         hb_q  <= hb_i;
         vb_q  <= vb_i;
      end else begin
         unique case (state)
            SC_LINE: begin
               if (px_last) begin
                  px    <= '0;
                  bcnt  <= '0;
                  state <= ln_last ? SC_VBLK : SC_HBLK;
               end else begin
                  px <= px_nxt[CW-1:0];
               end
            end
            SC_HBLK: begin
               if (hb_last) begin
                  state <= SC_LINE;
                  ln    <= ln_nxt[RW-1:0];
               end else begin
                  bcnt <= b_nxt[BW-1:0];
               end
            end
            SC_VBLK: begin
               if (vb_last) state <= SC_IDLE;
               else         bcnt  <= b_nxt[BW-1:0];
            end
            default: state <= SC_IDLE;
         endcase
      end
   end

   assign lv = (state == SC_LINE);
   assign fv = (state == SC_LINE) || (state == SC_HBLK);

   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fv && $past(fv)) |-> ($stable(col0) && $stable(row0) && $stable(w_q) &&
                             $stable(h_q) && $stable(hb_q)));

   // R2
   px_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lv |-> (px < w_q || px == '0));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SC_IDLE && single_shot && !trigger) |=> (state == SC_IDLE && !fv));

   // R3
   frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fv) |-> (lv && px == '0 && ln == '0));
endmodule

// File: rtl/pattern_fmt.sv
`timescale 1ns/1ps
module pattern_fmt
   import sensor_emu_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int CW      = 12,
   parameter int RW      = 11,
   parameter int COLS    = 2752,
   parameter int ROWS    = 2004,
   parameter int C_EDGE0 = 10,
   parameter int C_LIVE0 = 16,
   parameter int C_EDGE1 = 2608,
   parameter int C_DARK1 = 2618,
   parameter int R_EDGE0 = 50,
   parameter int R_LIVE0 = 54,
   parameter int R_EDGE1 = 1998,
   parameter int R_DARK1 = 2002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lv,
   input  logic [CW-1:0]     col,
   input  logic [RW-1:0]     row,
   input  logic              px_odd,
   input  logic              ln_odd,
   output logic [DATA_W-1:0] dout
);
   localparam int LOW_W = DATA_W - 4;

   region_t       col_kind, row_kind, kind;
   logic [LOW_W-1:0] low;

   initial begin
      data_width_chk: assert (DATA_W >= 5)
         else $error("data word too narrow for the pattern");
   end

   region_decode #(.N(COLS), .E0(C_EDGE0), .E1(C_LIVE0), .E2(C_EDGE1),
                   .E3(C_DARK1), .W(CW)) u_col_dec (.coord(col), .kind(col_kind));
   region_decode #(.N(ROWS), .E0(R_EDGE0), .E1(R_LIVE0), .E2(R_EDGE1),
                   .E3(R_DARK1), .W(RW)) u_row_dec (.coord(row), .kind(row_kind));

   assign kind = merge_region(col_kind, row_kind);

   generate
      if (LOW_W <= CW) begin : g_slice
         assign low = col[LOW_W-1:0];
      end else begin : g_pad
         assign low = {{(LOW_W-CW){1'b0}}, col};
      end
   endgenerate

   assign dout = lv ? {kind, ln_odd, px_odd, low} : '0;

   // R6
   region_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lv |-> (dout[DATA_W-1 -: 2] != 2'b11));

   // R7
   chan_col_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lv && $past(lv)) |-> (dout[DATA_W-4] != $past(dout[DATA_W-4])));

   // R7
   chan_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lv && $past(lv)) |-> $stable(dout[DATA_W-3]));
endmodule

// File: rtl/sensor_readout_emu.sv
`timescale 1ns/1ps
module sensor_readout_emu
   import sensor_emu_pkg::*;
#(
   parameter int COLS    = 2752,
   parameter int ROWS    = 2004,
   parameter int C_EDGE0 = 10,
   parameter int C_LIVE0 = 16,
   parameter int C_EDGE1 = 2608,
   parameter int C_DARK1 = 2618,
   parameter int R_EDGE0 = 50,
   parameter int R_LIVE0 = 54,
   parameter int R_EDGE1 = 1998,
   parameter int R_DARK1 = 2002,
   parameter int DATA_W  = 12,
   parameter int BLANK_W = 12,
   localparam int CW     = $clog2(COLS + 1),
   localparam int RW     = $clog2(ROWS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               single_shot,
   input  logic               trigger,
   input  logic [CW-1:0]      win_col,
   input  logic [RW-1:0]      win_row,
   input  logic [CW-1:0]      win_width,
   input  logic [RW-1:0]      win_height,
   input  logic [BLANK_W-1:0] hblank,
   input  logic [BLANK_W-1:0] vblank,
   output logic               fv,
   output logic               lv,
   output logic [DATA_W-1:0]  dout
);
   logic [CW-1:0] px, col0, phys_col;
   logic [RW-1:0] ln, row0, phys_row;

   scan_ctrl #(.CW(CW), .RW(RW), .BW(BLANK_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .single_shot(single_shot), .trigger(trigger),
      .col_i(win_col), .row_i(win_row), .w_i(win_width), .h_i(win_height),
      .hb_i(hblank), .vb_i(vblank),
      .fv(fv), .lv(lv), .px(px), .ln(ln), .col0(col0), .row0(row0)
   );

   assign phys_col = col0 + px;
   assign phys_row = row0 + ln;

   pattern_fmt #(
      .DATA_W(DATA_W), .CW(CW), .RW(RW), .COLS(COLS), .ROWS(ROWS),
      .C_EDGE0(C_EDGE0), .C_LIVE0(C_LIVE0), .C_EDGE1(C_EDGE1), .C_DARK1(C_DARK1),
      .R_EDGE0(R_EDGE0), .R_LIVE0(R_LIVE0), .R_EDGE1(R_EDGE1), .R_DARK1(R_DARK1)
   ) u_fmt (
      .clk(clk), .rst_n(rst_n), .lv(lv), .col(phys_col), .row(phys_row),
      .px_odd(px[0]), .ln_odd(ln[0]), .dout(dout)
   );
endmodule

// File: tb/sensor_readout_emu_test.sv
`timescale 1ns/1ps
module sensor_readout_emu_test;
   localparam int COLS = 40, ROWS = 24;
   localparam int CE0 = 2, CL0 = 4, CE1 = 32, CD1 = 36;
   localparam int RE0 = 2, RL0 = 4, RE1 = 18, RD1 = 21;
   localparam int CW = $clog2(COLS + 1), RW = $clog2(ROWS + 1), BW = 12;

   typedef struct packed {
      logic        fv;
      logic        lv;
      logic [11:0] d;
      logic [3:0]  tag;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0, single_shot = 1'b1, trigger = 1'b0;
   logic [CW-1:0] win_col = '0, win_width = '0;
   logic [RW-1:0] win_row = '0, win_height = '0;
   logic [BW-1:0] hblank = '0, vblank = '0;
   logic fv, lv;
   logic [11:0] dout;

   item_t q[$];
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sensor_readout_emu #(
      .COLS(COLS), .ROWS(ROWS),
      .C_EDGE0(CE0), .C_LIVE0(CL0), .C_EDGE1(CE1), .C_DARK1(CD1),
      .R_EDGE0(RE0), .R_LIVE0(RL0), .R_EDGE1(RE1), .R_DARK1(RD1),
      .DATA_W(12), .BLANK_W(BW)
   ) uut (
      .clk(clk), .rst_n(rst_n), .single_shot(single_shot), .trigger(trigger),
      .win_col(win_col), .win_row(win_row), .win_width(win_width),
      .win_height(win_height), .hblank(hblank), .vblank(vblank),
      .fv(fv), .lv(lv), .dout(dout)
   );

   function automatic int band(int v, int a, int b, int c, int e);
      if (v < a) return 0;
      if (v < b) return 1;
      if (v < c) return 2;
      if (v < e) return 1;
      return 0;
   endfunction

   function automatic string scen(logic [3:0] t);
      case (t)
         4'd1:    return "R8";
         4'd2:    return "R9";
         4'd3:    return "R10";
         default: return "R2";
      endcase
   endfunction

   task automatic push(logic f, logic l, logic [11:0] d, logic [3:0] t);
      item_t it;
      it.fv = f; it.lv = l; it.d = d; it.tag = t;
      q.push_back(it);
   endtask

   // expected sequence of one frame: R2 line/gap shape, R3 vblank, R5-R7 word
   task automatic expect_frame(int sc, int sr, int w, int h, int hb, int vb, logic [3:0] t);
      int we = (w == 0) ? 1 : w;
      int he = (h == 0) ? 1 : h;
      int hbe = (hb == 0) ? 1 : hb;
      int vbe = (vb == 0) ? 1 : vb;
      for (int l = 0; l < he; l++) begin
         for (int p = 0; p < we; p++) begin
            int c = sc + p;
            int r = sr + l;
            int kc = band(c, CE0, CL0, CE1, CD1);
            int kr = band(r, RE0, RL0, RE1, RD1);
            int k = (kc == 0 || kr == 0) ? 0 : ((kc == 2 && kr == 2) ? 2 : 1);
            logic [1:0] k2 = 2'(k);
            logic [7:0] c8 = 8'(c);
            push(1'b1, 1'b1, {k2, l[0], p[0], c8}, t);
         end
         if (l < he - 1)
            for (int g = 0; g < hbe; g++) push(1'b1, 1'b0, 12'h000, t);
      end
      for (int g = 0; g < vbe; g++) push(1'b0, 1'b0, 12'h000, t);
   endtask

   task automatic idle_items(int n, logic [3:0] t);
      for (int i = 0; i < n; i++) push(1'b0, 1'b0, 12'h000, t);
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      step();
   endtask

   task automatic set_win(int c, int r, int w, int h, int hb, int vb);
      win_col = CW'(c); win_row = RW'(r); win_width = CW'(w);
      win_height = RW'(h); hblank = BW'(hb); vblank = BW'(vb);
   endtask

   // monitor: pops one expected item per cycle and compares
   always @(negedge clk) begin
      if (q.size() != 0) begin
         item_t e;
         e = q.pop_front();
         checks++;
         if (fv !== e.fv) begin
            fails++;
            $display("FAIL %s (%s frame-valid) actual fv=%b expected fv=%b", e.fv ? "R2" : "R3",
                     scen(e.tag), fv, e.fv);
         end else if (lv !== e.lv) begin
            fails++;
            $display("FAIL R4 (%s line-valid) actual lv=%b expected lv=%b", scen(e.tag), lv, e.lv);
         end else if (dout[11:10] !== e.d[11:10]) begin
            fails++;
            $display("FAIL R6 (%s region) actual %h expected %h", scen(e.tag), dout, e.d);
         end else if (dout[9:8] !== e.d[9:8]) begin
            fails++;
            $display("FAIL R7 (%s channel) actual %h expected %h", scen(e.tag), dout, e.d);
         end else if (dout[7:0] !== e.d[7:0]) begin
            fails++;
            $display("FAIL %s (R5 column bits) actual %h expected %h", scen(e.tag), dout, e.d);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL R2 watchdog: actual run still busy, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R1: outputs quiet in reset
      set_win(0, 0, 8, 5, 3, 4);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         checks++;
         if (fv !== 1'b0 || lv !== 1'b0 || dout !== 12'h000) begin
            fails++;
            $display("FAIL R1 actual fv=%b lv=%b dout=%h expected 0 0 000", fv, lv, dout);
         end
      end
      step();
      rst_n = 1'b1;

      // R9: idle without trigger
      idle_items(4, 4'd2);
      drain();

      // R9 single shot over the leading dark/boundary corner, late trigger and R8 mid-frame write
      set_win(0, 0, 8, 5, 3, 4);
      trigger = 1'b1;
      idle_items(1, 4'd2);
      expect_frame(0, 0, 8, 5, 3, 4, 4'd2);
      idle_items(5, 4'd2);
      step();
      trigger = 1'b0;
      repeat (5) step();
      trigger = 1'b1;
      win_col = CW'(20);
      win_row = RW'(7);
      step();
      trigger = 1'b0;
      drain();

      // R2/R3 free-running frames at the trailing edges, R8 reload at the seam
      set_win(30, 16, 8, 6, 2, 3);
      single_shot = 1'b0;
      idle_items(1, 4'd0);
      expect_frame(30, 16, 8, 6, 2, 3, 4'd0);
      expect_frame(5, 3, 5, 3, 1, 2, 4'd1);
      idle_items(4, 4'd2);
      repeat (5) step();
      set_win(5, 3, 5, 3, 1, 2);
      repeat (60) step();
      single_shot = 1'b1;
      drain();

      // R10: zero width and blanking counts
      set_win(10, 10, 0, 2, 0, 0);
      trigger = 1'b1;
      idle_items(1, 4'd3);
      expect_frame(10, 10, 0, 2, 0, 0, 4'd3);
      idle_items(3, 4'd3);
      step();
      trigger = 1'b0;
      drain();

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule